// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pair Issue Decider

This block decides, once per cycle, which instructions of a fetched pair may leave the decode stage of a two-wide in-order front end. Each fetch delivers an aligned pair. The left slot carries an instruction of the integer class, which includes loads into either register file. The right slot carries a floating-point operation. The block sees the class tag, the source specifiers and the destination specifier of the left instruction. It sees the class tag and the source specifiers of the right instruction. It returns three signals: issue for the left slot, issue for the right slot, and a replay flag. The replay flag tells the fetch logic to present the held right instruction again, in the left position, on the next cycle.

Internally the block keeps a one-entry record of the load that the previous cycle issued, if there was one. It uses this record to enforce the one-cycle load delay. That delay blocks the partner instruction in the same pair and both instructions of the following pair, so one load shadows three instruction slots. Register hazards count only inside one register file. Integer-class instructions read the integer file. Floating-point operations read the FP file.

Top module: `pair_issue`

## Requirements
- R1: After reset no load is on record, so the first pair with a correct slot order and no same-pair dependency issues in both slots.
- R2: When the left slot is not valid, neither slot issues and replay stays low, whatever the right slot holds.
- R3: The right slot never issues unless the left slot issues in the same cycle.
- R4: Class codes are 0 integer ALU, 1 integer load, 2 FP load, 3 FP operation. When the left class is 3, or the right class is not 3, only the left instruction issues and replay is raised for a valid right instruction.
- R5: When the left instruction is an FP load whose destination equals any source of the right FP operation, the left instruction issues, the right does not, and replay is raised.
- R6: When the previous cycle issued an integer load and the left instruction has a source equal to that load's destination, neither slot issues and replay stays low.
- R7: When the previous cycle issued an FP load and the right FP operation has a source equal to that load's destination, the left instruction issues, the right does not, and replay is raised.
- R8: A load destination causes a hazard only for sources in the same register file. An integer load never stalls an FP source, and an FP load never stalls an integer-class source.
- R9: The load delay lasts one cycle. Once that cycle has passed, the same dependent instruction issues, including an FP operation replayed into the left slot.
- R10: Replay is high exactly when the left slot issues, the right slot is valid, and the right slot does not issue.
- R11: An FP load in the left slot paired with an independent FP operation in the right slot issues in both slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_vld | input | 1 | Left slot holds an instruction |
| lf_cls | input | 2 | Left class tag (0 int ALU, 1 int load, 2 FP load, 3 FP op) |
| lf_src | input | NUM_SRC*REG_W | Left source specifiers, source 0 in the low bits |
| lf_dst | input | REG_W | Left destination specifier |
| rt_vld | input | 1 | Right slot holds an instruction |
| rt_cls | input | 2 | Right class tag, same coding |
| rt_src | input | NUM_SRC*REG_W | Right source specifiers, source 0 in the low bits |
| issue_left | output | 1 | Left instruction issues this cycle |
| issue_right | output | 1 | Right instruction issues this cycle |
| replay_right | output | 1 | Right instruction held; present it in the left slot next cycle |

## Verification
The bench builds the block with REG_W = 5, NUM_SRC = 2 and dual issue enabled. Two sources per slot let a dependency be placed in either source position, so the comparator for each position is exercised separately. Five-bit specifiers give enough distinct register numbers to set a matching and a non-matching specifier side by side in one pair. The same number is also reused across the two register files, which shows that a match counts only within one file.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;
   typedef enum logic [1:0] {
      CL_IALU = 2'd0,
      CL_ILD  = 2'd1,
      CL_FLD  = 2'd2,
      CL_FOP  = 2'd3
   } icls_e;

   function automatic logic cls_is_load(input logic [1:0] c);
      return (c == CL_ILD) || (c == CL_FLD);
   endfunction

   function automatic logic cls_reads_fp(input logic [1:0] c);
      return c == CL_FOP;
   endfunction
endpackage

// File: rtl/pair_regmatch.sv
module pair_regmatch #(
   parameter int REG_W   = 5,
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC*REG_W-1:0] srcs,
   input  logic [REG_W-1:0]         key,
   input  logic                     key_vld,
   output logic                     hit
);
   logic [NUM_SRC-1:0] eq;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
      assign eq[g] = (srcs[g*REG_W +: REG_W] == key);
   end

   assign hit = key_vld & (|eq);
endmodule

// File: rtl/pair_ld_shadow.sv
module pair_ld_shadow #(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_issued,
   input  logic             ld_to_fp,
   input  logic [REG_W-1:0] ld_dst,
   output logic             sh_vld,
   output logic             sh_fp,
   output logic [REG_W-1:0] sh_dst
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_vld <= 1'b0;
         sh_fp  <= 1'b0;
         sh_dst <= '0;
      end else begin
         sh_vld <= ld_issued;
         sh_fp  <= ld_to_fp;
         sh_dst <= ld_dst;
      end
   end

   // R9: the record lives for exactly one cycle unless a new load refreshes it
   p_shadow_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_vld && !ld_issued) |=> !sh_vld);
endmodule

// File: rtl/pair_issue.sv
module pair_issue
   import pair_issue_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter int NUM_SRC = 2,
   parameter bit DUAL_EN = 1'b1,
   localparam int SRC_W  = NUM_SRC * REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lf_vld,
   input  logic [1:0]       lf_cls,
   input  logic [SRC_W-1:0] lf_src,
   input  logic [REG_W-1:0] lf_dst,
   input  logic             rt_vld,
   input  logic [1:0]       rt_cls,
   input  logic [SRC_W-1:0] rt_src,
   output logic             issue_left,
   output logic             issue_right,
   output logic             replay_right
);
   if (REG_W < 1 || NUM_SRC < 1) begin : g_bad_cfg
      $error("pair_issue: REG_W and NUM_SRC must be at least 1");
   end

   logic             sh_vld, sh_fp;
   logic [REG_W-1:0] sh_dst;
   logic             lf_prev_hit, rt_prev_hit, rt_same_hit;
   logic             lf_fp_reader, pair_order_ok;

   assign lf_fp_reader  = cls_reads_fp(lf_cls);
   assign pair_order_ok = !cls_reads_fp(lf_cls) && (rt_cls == CL_FOP);

   // previous-cycle load against left sources, same register file only
   pair_regmatch #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_lf_prev (
      .srcs(lf_src), .key(sh_dst), .key_vld(sh_vld && (sh_fp == lf_fp_reader)),
      .hit(lf_prev_hit));

   // previous-cycle FP load against right FP sources
   pair_regmatch #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_rt_prev (
      .srcs(rt_src), .key(sh_dst), .key_vld(sh_vld && sh_fp),
      .hit(rt_prev_hit));

   // FP load in the left slot against its partner's FP sources
   pair_regmatch #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_rt_same (
      .srcs(rt_src), .key(lf_dst), .key_vld(lf_vld && (lf_cls == CL_FLD)),
      .hit(rt_same_hit));

   assign issue_left = lf_vld && !lf_prev_hit;

   if (DUAL_EN) begin : g_dual
      assign issue_right = issue_left && rt_vld && pair_order_ok &&
                           !rt_prev_hit && !rt_same_hit;
   end else begin : g_single
      logic unused_haz;
      assign unused_haz  = rt_prev_hit ^ rt_same_hit ^ pair_order_ok;
      assign issue_right = 1'b0;
   end

   assign replay_right = issue_left && rt_vld && !issue_right;

   pair_ld_shadow #(.REG_W(REG_W)) u_shadow (
      .clk(clk), .rst_n(rst_n),
      .ld_issued(issue_left && cls_is_load(lf_cls)),
      .ld_to_fp(lf_cls == CL_FLD),
      .ld_dst(lf_dst),
      .sh_vld(sh_vld), .sh_fp(sh_fp), .sh_dst(sh_dst));

   p_right_needs_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_right |-> issue_left);

   p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_right |-> (lf_cls != CL_FOP) && (rt_cls == CL_FOP));

   p_same_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lf_cls == CL_FLD && rt_vld &&
       (rt_src[REG_W-1:0] == lf_dst)) |-> !issue_right);

   p_int_ld_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(issue_left) && $past(lf_cls) == CL_ILD &&
       lf_cls != CL_FOP && lf_src[REG_W-1:0] == $past(lf_dst)) |-> !issue_left);

   p_replay_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      replay_right |-> (!issue_right && issue_left));
endmodule

// File: tb/pair_issue_tb.sv
module pair_issue_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 5;
   localparam int NS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lf_vld = 1'b0, rt_vld = 1'b0;
   logic [1:0] lf_cls = 2'd0, rt_cls = 2'd0;
   logic [NS*RW-1:0] lf_src = '0, rt_src = '0;
   logic [RW-1:0] lf_dst = '0;
   logic il, ir, rp;
   int n_chk = 0, n_bad = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pair_issue #(.REG_W(RW), .NUM_SRC(NS), .DUAL_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lf_vld(lf_vld), .lf_cls(lf_cls), .lf_src(lf_src), .lf_dst(lf_dst),
      .rt_vld(rt_vld), .rt_cls(rt_cls), .rt_src(rt_src),
      .issue_left(il), .issue_right(ir), .replay_right(rp));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   // drive a pair at the falling edge and settle before checking
   task automatic put(input logic lv, input logic [1:0] lc, input int ls1, input int ls0,
                      input int ld, input logic rv, input logic [1:0] rc,
                      input int rs1, input int rs0);
      @(negedge clk);
      lf_vld = lv; lf_cls = lc; lf_src = {RW'(ls1), RW'(ls0)}; lf_dst = RW'(ld);
      rt_vld = rv; rt_cls = rc; rt_src = {RW'(rs1), RW'(rs0)};
      #1;
   endtask

   task automatic chk(input string req, input logic el, input logic er, input logic ep);
      n_chk++;
      if (il !== el || ir !== er || rp !== ep) begin
         n_bad++;
         $display("FAIL %s: got L=%b R=%b replay=%b expected L=%b R=%b replay=%b",
                  req, il, ir, rp, el, er, ep);
      end
   endtask

   task automatic t_reset_r1();
      put(1, 2'd0, 3, 4, 8, 1, 2'd3, 1, 2);
      chk("R1 first pair after reset", 1, 1, 0);
   endtask

   task automatic t_invalid_r2();
      put(0, 2'd0, 1, 2, 3, 1, 2'd3, 1, 2);
      chk("R2 left invalid", 0, 0, 0);
   endtask

   task automatic t_order_r4();
      put(1, 2'd3, 1, 2, 3, 1, 2'd3, 4, 5);
      chk("R4 FP op in left slot", 1, 0, 1);
      put(1, 2'd0, 1, 2, 3, 1, 2'd1, 4, 5);
      chk("R4 non-FP in right slot R10", 1, 0, 1);
      put(1, 2'd0, 1, 2, 3, 0, 2'd3, 4, 5);
      chk("R10 right invalid no replay", 1, 0, 0);
   endtask

   task automatic t_same_pair_r5();
      put(1, 2'd2, 1, 2, 6, 1, 2'd3, 6, 1);
      chk("R5 FP load feeds partner src1", 1, 0, 1);
      put(1, 2'd2, 1, 2, 6, 1, 2'd3, 0, 6);
      chk("R5 FP load feeds partner src0", 1, 0, 1);
   endtask

   task automatic t_int_delay_r6();
      put(1, 2'd0, 1, 1, 1, 0, 2'd3, 0, 0);
      put(1, 2'd1, 1, 2, 7, 1, 2'd3, 1, 2);
      chk("R6 int load issues with FP op", 1, 1, 0);
      put(1, 2'd0, 7, 0, 3, 1, 2'd3, 1, 2);
      chk("R6 next pair uses load dst", 0, 0, 0);
      put(1, 2'd0, 7, 0, 3, 1, 2'd3, 1, 2);
      chk("R9 held pair issues after delay", 1, 1, 0);
   endtask

   task automatic t_fp_delay_r7();
      put(1, 2'd2, 1, 2, 9, 1, 2'd3, 1, 2);
      chk("R11 FP load with independent FP op", 1, 1, 0);
      put(1, 2'd0, 1, 2, 3, 1, 2'd3, 9, 3);
      chk("R7 next right uses FP load dst", 1, 0, 1);
      put(1, 2'd3, 9, 3, 4, 0, 2'd3, 0, 0);
      chk("R9 replayed FP op in left slot", 1, 0, 0);
   endtask

   task automatic t_files_r8();
      put(1, 2'd1, 1, 2, 5, 0, 2'd3, 0, 0);
      put(1, 2'd0, 1, 2, 3, 1, 2'd3, 5, 0);
      chk("R8 int load vs FP source", 1, 1, 0);
      put(1, 2'd2, 1, 2, 9, 0, 2'd3, 0, 0);
      put(1, 2'd2, 9, 9, 4, 1, 2'd3, 1, 2);
      chk("R8 FP load vs int address source", 1, 1, 0);
      put(1, 2'd1, 1, 2, 6, 1, 2'd3, 6, 6);
      chk("R8 int load dst vs partner FP src", 1, 1, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R2 outputs idle in reset", 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_r1();
      t_invalid_r2();
      t_order_r4();
      t_same_pair_r5();
      t_int_delay_r6();
      t_fp_delay_r7();
      t_files_r8();
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule